// File: doc/BRIEF.md
# Interrupt Redirection and Message Generator

This block collects interrupt requests arriving on a set of input lines and turns each one into a message-signalled interrupt. A message is a 32-bit address word and a 32-bit data word. The address and data are built from a 64-bit routing entry that belongs to the pin. A register block outside this module holds the routing entries and drives them in as one flat vector. The block keeps two pieces of state per pin. The first is a pending bit. The second is a busy flag for level-triggered pins, which blocks another delivery until the processor signals end-of-interrupt for that vector.

Each pin is either edge-triggered or level-triggered. An edge pin latches a request on a rising input and gives up the request once its message has been issued. A level pin has a pending bit that follows its input. After a level pin delivers, its busy flag blocks further messages until an end-of-interrupt with a matching vector arrives. The block takes the lowest-numbered serviceable pin, loads its message into an output register and holds it there under a valid/ready handshake. It can load a new message in the same cycle that the previous one is accepted.

Routing entry layout (bit positions are fixed because the message fields are taken from them):
- bits 7:0: vector
- bits 10:8: delivery mode
- bit 11: destination mode
- bit 15: trigger, where 1 means level and 0 means edge
- bit 16: mask, where 1 means masked
- bits 63:48: destination

All other bits are ignored.

Top module: `irq_msg_gen`

## Requirements
- R1: A rising edge on an unmasked edge pin produces one message. The address is 0xFEE00000 with the 16-bit destination placed in address bits 19:4 and the destination-mode bit placed in address bit 2. The data word holds the vector in bits 7:0, the delivery mode in bits 10:8 and the trigger bit in bit 15. All other data bits are zero, and address bits 3 and 1:0 are zero.
- R2: A rising edge on an edge pin whose entry is masked is discarded. Unmasking the pin later produces no message.
- R3: An edge request that was latched before the pin became masked stays pending. No message is sent while the mask is set. Exactly one message is sent once the mask is cleared.
- R4: An unmasked level pin with its input high delivers once and sets its busy flag (`remote_irr`). No further message is sent while the busy flag is set, even with the input still high.
- R5: An end-of-interrupt whose vector matches a busy level pin clears that pin's busy flag. If the input is still high, the pin delivers again. An end-of-interrupt with any other vector changes nothing.
- R6: On a level pin, the pending bit follows the input. A request that is raised and dropped while the pin is masked leaves nothing to deliver after unmasking.
- R7: Input 0 is routed to pin 2 and uses pin 2's entry. Inputs numbered at or above the pin count have no effect.
- R8: When several pins are pending together, their messages leave in ascending pin order, one per accepted transfer.
- R9: While `msg_valid` is high and `msg_ready` is low, the address and data stay stable and valid stays high.
- R10: A pin whose entry is switched to edge trigger has its busy flag cleared on the next clock.
- R11: After reset, `msg_valid` is low and all busy flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NIN (26) | Active-high interrupt input lines |
| rte_flat | input | NPINS*64 (1536) | Routing entries; pin p occupies bits p*64+63 down to p*64 |
| eoi_valid | input | 1 | End-of-interrupt strobe, one cycle |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | A message is held on the output |
| msg_ready | input | 1 | Receiver accepts the message this cycle |
| msg_addr | output | 32 | Message address word |
| msg_data | output | 32 | Message data word |
| remote_irr | output | NPINS (24) | Per-pin busy flag of level-triggered pins |

## Verification
The assertions assume that each input line is a clean synchronous level that changes only between clock edges. They also assume that a routing entry changes only by a register write, so it stays constant over many cycles. The busy-flag checks further rely on two conditions: end-of-interrupt is a single-cycle strobe, and no two level pins share a vector while both are busy. The stimulus drives every input one time unit after a rising edge and holds it for whole cycles. It changes routing entries only while the affected input is idle or the pin is masked. It gives each active pin a distinct vector.

// File: rtl/irq_msg_gen.sv
module irq_msg_gen #(
  parameter int NPINS = 24,
  parameter int NIN = 26,
  parameter logic [31:0] MSG_BASE = 32'hFEE0_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NIN-1:0]     irq_in,
  input  logic [NPINS*64-1:0] rte_flat,
  input  logic               eoi_valid,
  input  logic [7:0]         eoi_vector,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [31:0]        msg_addr,
  output logic [31:0]        msg_data,
  output logic [NPINS-1:0]   remote_irr
);
  localparam logic [NPINS-1:0] ONE = {{(NPINS-1){1'b0}}, 1'b1};

  logic [63:0] ent [NPINS];
  logic [NPINS-1:0] src, src_q, irr, masked, lvl, vec_hit, svc, pick, ld_oh;
  logic [NPINS-1:0] unused_rsv;
  logic [63:0] sel_ent;
  logic ld;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign ent[g]        = rte_flat[g*64 +: 64];
    assign masked[g]     = ent[g][16];
    assign lvl[g]        = ent[g][15];
    assign vec_hit[g]    = ent[g][7:0] == eoi_vector;
    assign unused_rsv[g] = ^{ent[g][47:17], ent[g][14:12]};
  end

  if (NIN > NPINS) begin : g_extra
    logic unused_in;
    assign unused_in = ^irq_in[NIN-1:NPINS];
  end

  always_comb begin
    src = '0;
    for (int i = 1; i < NPINS; i++)
      if (i < NIN) src[i] = irq_in[i];
    src[2] = src[2] | irq_in[0];
  end

  assign svc   = irr & ~masked & (~lvl | ~remote_irr);
  assign pick  = svc & (~svc + ONE);
  assign ld    = (|svc) && (!msg_valid || msg_ready);
  assign ld_oh = ld ? pick : '0;

  always_comb begin
    sel_ent = '0;
    for (int i = 0; i < NPINS; i++)
      if (pick[i]) sel_ent = sel_ent | ent[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q      <= '0;
      irr        <= '0;
      remote_irr <= '0;
    end else begin
      src_q <= src;
      for (int i = 0; i < NPINS; i++) begin
        if (lvl[i])
          irr[i] <= src[i];
        else if (src[i] && !src_q[i] && !masked[i])
          irr[i] <= 1'b1;
        else if (ld_oh[i])
          irr[i] <= 1'b0;

        if (!lvl[i])
          remote_irr[i] <= 1'b0;
        else if (eoi_valid && vec_hit[i])
          remote_irr[i] <= 1'b0;
        else if (ld_oh[i])
          remote_irr[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (ld) begin
      msg_valid <= 1'b1;
      msg_addr  <= MSG_BASE | {12'b0, sel_ent[63:48], 4'b0} | {29'b0, sel_ent[11], 2'b0};
      msg_data  <= {16'b0, sel_ent[15], 4'b0, sel_ent[10:8], sel_ent[7:0]};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_msg_gen_chk.sv
module irq_msg_gen_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [31:0]      msg_addr,
  input logic [31:0]      msg_data,
  input logic [NPINS-1:0] remote_irr,
  input logic [NPINS-1:0] trig_lvl
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_msg_fmt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:16] == 16'h0 && msg_data[14:11] == 4'h0 &&
                   msg_addr[3] == 1'b0 && msg_addr[1:0] == 2'b00));

  assert_single_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(remote_irr & ~$past(remote_irr)) <= 1);

  assert_busy_with_msg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(remote_irr & ~$past(remote_irr))) |-> msg_valid);

  for (genvar g = 0; g < NPINS; g++) begin : g_edge
    assert_edge_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (remote_irr[g] && !trig_lvl[g]) |=> !remote_irr[g]);
  end
endmodule

bind irq_msg_gen irq_msg_gen_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .remote_irr(remote_irr), .trig_lvl(lvl)
);

// File: tb/sim_irq_msg_gen.sv
module sim_irq_msg_gen;
  localparam int NPINS = 24;
  localparam int NIN = 26;

  typedef struct packed {
    logic [4:0]  inp;
    logic [7:0]  vec;
    logic [2:0]  dm;
    logic        dmode;
    logic [15:0] dest;
    logic [31:0] ea;
    logic [31:0] ed;
  } row_t;

  localparam row_t TBL [4] = '{
    '{5'd5,  8'h31, 3'd0, 1'b0, 16'h0001, 32'hFEE0_0010, 32'h0000_0031},
    '{5'd9,  8'hA7, 3'd5, 1'b1, 16'h00FF, 32'hFEE0_0FF4, 32'h0000_05A7},
    '{5'd23, 8'hFE, 3'd7, 1'b1, 16'hFFFF, 32'hFEEF_FFF4, 32'h0000_07FE},
    '{5'd0,  8'h40, 3'd1, 1'b0, 16'h1234, 32'hFEE1_2340, 32'h0000_0140}
  };

  logic clk = 0, rst_n = 0, eoi_valid = 0, msg_ready = 1, msg_valid;
  logic [NIN-1:0] irq_in = '0;
  logic [7:0] eoi_vector = '0;
  logic [31:0] msg_addr, msg_data;
  logic [NPINS-1:0] remote_irr;
  logic [63:0] rte [NPINS];
  logic [NPINS*64-1:0] rte_flat;
  logic [31:0] log_a [16], log_d [16];
  int nlog = 0, nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < NPINS; i++) rte_flat[i*64 +: 64] = rte[i];

  irq_msg_gen #(.NPINS(NPINS), .NIN(NIN)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rte_flat(rte_flat),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
    .remote_irr(remote_irr)
  );

  always @(negedge clk)
    if (rst_n && msg_valid && msg_ready && nlog < 16) begin
      log_a[nlog] = msg_addr;
      log_d[nlog] = msg_data;
      nlog = nlog + 1;
    end

  function automatic logic [63:0] mk(input logic [7:0] v, input logic [2:0] dm,
      input logic dmode, input logic level, input logic msk, input logic [15:0] dest);
    mk = {dest, 31'b0, msk, level, 3'b0, dmode, dm, v};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input int i);
    irq_in[i] = 1'b1;
    tick(1);
    irq_in[i] = 1'b0;
    tick(4);
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_vector = v;
    eoi_valid = 1'b1;
    tick(1);
    eoi_valid = 1'b0;
    tick(4);
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPINS; i++) rte[i] = mk(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R11 valid", {31'b0, msg_valid}, 32'h0);
    check("R11 busy", {8'b0, remote_irr}, 32'h0);

    // R1 and R7 through the vector table
    for (int r = 0; r < 4; r++) begin
      int pin;
      pin = (TBL[r].inp == 5'd0) ? 2 : int'(TBL[r].inp);
      rte[pin] = mk(TBL[r].vec, TBL[r].dm, TBL[r].dmode, 1'b0, 1'b0, TBL[r].dest);
      tick(1);
      nlog = 0;
      pulse(int'(TBL[r].inp));
      check("R1 count", nlog, 1);
      check("R1 addr", log_a[0], TBL[r].ea);
      check("R1 data", log_d[0], TBL[r].ed);
      rte[pin] = mk(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
    end

    // R7: inputs beyond the pin count
    nlog = 0;
    pulse(24);
    pulse(25);
    check("R7 high inputs ignored", nlog, 0);

    // R2: masked edge discarded
    rte[9] = mk(8'h29, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
    tick(1);
    nlog = 0;
    pulse(9);
    rte[9][16] = 1'b0;
    tick(4);
    check("R2 masked edge dropped", nlog, 0);

    // R8: ascending order
    rte[3]  = mk(8'h03, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
    rte[7]  = mk(8'h07, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
    rte[12] = mk(8'h0C, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
    tick(1);
    nlog = 0;
    irq_in[12] = 1'b1; irq_in[3] = 1'b1; irq_in[7] = 1'b1;
    tick(1);
    irq_in = '0;
    tick(6);
    check("R8 count", nlog, 3);
    check("R8 first", log_d[0], 32'h03);
    check("R8 second", log_d[1], 32'h07);
    check("R8 third", log_d[2], 32'h0C);

    // R9 hold, R3 pending across mask
    rte[5] = mk(8'h35, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
    tick(1);
    nlog = 0;
    msg_ready = 1'b0;
    pulse(5);
    pulse(9);
    check("R9 valid held", {31'b0, msg_valid}, 32'h1);
    check("R9 data held", msg_data, 32'h35);
    tick(3);
    check("R9 data still held", msg_data, 32'h35);
    check("R9 nothing accepted", nlog, 0);
    rte[9][16] = 1'b1;
    tick(1);
    msg_ready = 1'b1;
    tick(5);
    check("R3 only first sent while masked", nlog, 1);
    rte[9][16] = 1'b0;
    tick(5);
    check("R3 sent after unmask", nlog, 2);
    check("R3 pending pin data", log_d[1], 32'h29);

    // R4, R5: level pin and end-of-interrupt
    rte[6] = mk(8'h55, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0);
    tick(1);
    nlog = 0;
    irq_in[6] = 1'b1;
    tick(8);
    check("R4 single delivery", nlog, 1);
    check("R4 level data", log_d[0], 32'h8055);
    check("R4 level addr", log_a[0], 32'hFEE0_0000);
    check("R4 busy set", {31'b0, remote_irr[6]}, 32'h1);
    eoi(8'h56);
    check("R5 other vector no effect", nlog, 1);
    check("R5 busy kept", {31'b0, remote_irr[6]}, 32'h1);
    eoi(8'h55);
    check("R5 redelivery", nlog, 2);
    irq_in[6] = 1'b0;
    tick(1);
    eoi(8'h55);
    check("R5 no send after drop", nlog, 2);
    check("R5 busy cleared", {31'b0, remote_irr[6]}, 32'h0);

    // R6: level pending follows input while masked
    rte[6][16] = 1'b1;
    tick(1);
    irq_in[6] = 1'b1;
    tick(2);
    irq_in[6] = 1'b0;
    tick(2);
    rte[6][16] = 1'b0;
    tick(5);
    check("R6 dropped level not sent", nlog, 2);

    // R10: switching to edge clears busy
    irq_in[6] = 1'b1;
    tick(4);
    irq_in[6] = 1'b0;
    tick(2);
    check("R10 busy before switch", {31'b0, remote_irr[6]}, 32'h1);
    rte[6][15] = 1'b0;
    tick(2);
    check("R10 busy cleared", {31'b0, remote_irr[6]}, 32'h0);
    check("R10 message count", nlog, 3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule